// File: doc/BRIEF.md
# Line-Interface Interrupt Enable/Status Unit

This block collects alarm and error indications from a line interface's transmit and receive paths and turns them into one active-high interrupt. It watches four level-type alarm inputs: line-driver failure, receive loss of signal, receive loss of lock, and elastic-buffer near-limit. It also watches two event-type sources: a single-cycle PRBS bit-error pulse and a PRBS error counter. Each source has a sticky status bit and a matching enable bit. The interrupt is raised while any status bit is set and its enable bit is also set.

The alarm inputs pass through one register stage. A status bit is set whenever that registered level differs from its value one cycle earlier, so both the rising and the falling edge of an alarm are reported. The counter is watched by a two-state machine with the states `SAT_BELOW` and `SAT_HELD`:

- `SAT_BELOW` moves to `SAT_HELD` when the counter equals all ones. That transition produces the saturation event.
- `SAT_HELD` returns to `SAT_BELOW` as soon as the counter holds any other value.
- In every other case the machine stays in its current state and produces no event.

The near-limit source only has meaning while the jitter attenuator runs. When the attenuator-enable input is low, that source's changes are dropped and its interrupt contribution is masked.

Software reaches the registers over a simple single-cycle register bus. Read data appears registered one cycle after the read. Reading the status register returns its value and clears it. An event that arrives in the same cycle as that read is still kept.

Top module: `lif_irq_unit`

## Requirements
- R1: After reset the enable register, the status register, `irq` and `bus_rdata` are all zero.
- R2: The enable register sits at address 0x01 and is readable and writable in bits [5:0]. The bit order is: 0 driver failure, 1 loss of signal, 2 loss of lock, 3 buffer near-limit, 4 PRBS error, 5 counter saturation. Bits [7:6] read as 0.
- R3: The status register sits at address 0x02 and uses the same bit order as R2. Writes to it have no effect. A read of any other address returns 0.
- R4: When one of the four alarm inputs changes level, in either direction, its status bit is set at the second rising edge after the new level is presented. The bit is never set without such a change.
- R5: While `ja_en` is low (as registered alongside the alarms), changes of `fifo_near` do not set status bit 3. Status bit 3 also does not contribute to `irq` while `ja_en` is low.
- R6: A high `prbs_err` at a rising edge sets status bit 4 at that edge.
- R7: Status bit 5 is set at the edge where `prbs_cnt` is first seen equal to 0xFFFF. It is not set again while the counter stays there. It is set again after the counter has left 0xFFFF and returned to it.
- R8: A read (`bus_sel`=1, `bus_wr`=0) presents the addressed register's pre-edge value on `bus_rdata` after the next rising edge. `bus_rdata` is 0 in cycles without a read. A status read clears all status bits.
- R9: An event that arrives in the same cycle as a clearing status read leaves its status bit set after that read.
- R10: `irq` is high exactly when some status bit and its enable bit are both set, with bit 3 also qualified as R5 describes. It stays high until the status is cleared or the enable bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drv_fail | input | 1 | Line-driver failure level |
| rx_los | input | 1 | Receive loss-of-signal level |
| rx_lol | input | 1 | Receive loss-of-lock level |
| fifo_near | input | 1 | Jitter buffer within 2 bits of overflow or underflow |
| ja_en | input | 1 | Jitter attenuator enabled |
| prbs_err | input | 1 | PRBS bit-error pulse |
| prbs_cnt | input | CNT_W | PRBS error counter value |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt, active high |

## Verification
The bench builds the unit with its default parameters: an 8-bit address, 8-bit data and a 16-bit counter. With these values the counter's all-ones value is exactly 0xFFFF, so the bench can hold the counter at saturation, take it away and bring it back. The register addresses 0x01 and 0x02 are reached together with a spare address. With the full 8-bit data path, the unused upper enable bits can be written and shown to read back as zero. A behavioural model predicts `irq` and `bus_rdata` on every cycle. This covers both edge directions of each alarm, attenuator masking, reads that coincide with events, and re-entry into saturation.

// File: rtl/lif_irq_pkg.sv
package lif_irq_pkg;

    localparam int NUM_SRC  = 6;
    localparam int NUM_ALM  = 4;

    localparam int SRC_DRV  = 0;
    localparam int SRC_LOS  = 1;
    localparam int SRC_LOL  = 2;
    localparam int SRC_FIFO = 3;
    localparam int SRC_PRBS = 4;
    localparam int SRC_SAT  = 5;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef enum logic [0:0] {
        SAT_BELOW = 1'b0,
        SAT_HELD  = 1'b1
    } sat_state_e;

endpackage

// File: rtl/lif_alarm_edge.sv
module lif_alarm_edge
    import lif_irq_pkg::*;
#(
    parameter int NUM      = NUM_ALM,
    parameter int GATE_IDX = SRC_FIFO
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] alarm_in,
    input  logic           ja_en,
    output logic [NUM-1:0] chg
);

    logic [NUM-1:0] lvl_q;
    logic [NUM-1:0] lvl_prev_q;
    logic           ja_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ja_q <= 1'b0;
        end else begin
            ja_q <= ja_en;
        end
    end

    for (genvar i = 0; i < NUM; i++) begin : g_alm
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_q[i]      <= 1'b0;
                lvl_prev_q[i] <= 1'b0;
            end else begin
                lvl_q[i]      <= alarm_in[i];
                lvl_prev_q[i] <= lvl_q[i];
            end
        end

        if (i == GATE_IDX) begin : g_gated
            assign chg[i] = (lvl_q[i] ^ lvl_prev_q[i]) & ja_q;
        end else begin : g_plain
            assign chg[i] = lvl_q[i] ^ lvl_prev_q[i];
        end
    end

    AST_FIFO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ja_en) |-> !chg[GATE_IDX]) else $error("fifo change while ja off"); // R5

endmodule

// File: rtl/lif_sat_fsm.sv
module lif_sat_fsm
    import lif_irq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    output logic             sat_evt
);

    localparam logic [CNT_W-1:0] SAT_VAL = {CNT_W{1'b1}};

    sat_state_e state_q;
    sat_state_e state_d;
    logic       at_max;

    assign at_max = (cnt == SAT_VAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SAT_BELOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sat_evt = 1'b0;
        unique case (state_q)
            SAT_BELOW: begin
                if (at_max) begin
                    state_d = SAT_HELD;
                    sat_evt = 1'b1;
                end
            end
            SAT_HELD: begin
                if (!at_max) begin
                    state_d = SAT_BELOW;
                end
            end
            default: state_d = SAT_BELOW;
        endcase
    end

    AST_SAT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sat_evt |=> !sat_evt) else $error("saturation reported twice"); // R7

endmodule

// File: rtl/lif_irq_regs.sv
module lif_irq_regs
    import lif_irq_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 8,
    parameter logic [ADDR_W-1:0] EN_ADDR = 8'h01,
    parameter logic [ADDR_W-1:0] ST_ADDR = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  src_vec_t          evt,
    output src_vec_t          en_q,
    output src_vec_t          stat_q,
    output logic              rd_clr,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int PAD_W = DATA_W - NUM_SRC;

    logic     rd_hit;
    logic     en_wr;
    logic     st_wr;
    src_vec_t rd_sel;
    logic     unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

    assign rd_hit = bus_sel && !bus_wr;
    assign en_wr  = bus_sel && bus_wr && (bus_addr == EN_ADDR);
    assign st_wr  = bus_sel && bus_wr && (bus_addr == ST_ADDR);
    assign rd_clr = rd_hit && (bus_addr == ST_ADDR);

    always_comb begin
        rd_sel = '0;
        if (bus_addr == EN_ADDR) begin
            rd_sel = en_q;
        end else if (bus_addr == ST_ADDR) begin
            rd_sel = stat_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= bus_wdata[NUM_SRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (rd_clr ? '0 : stat_q) | evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_hit ? {{PAD_W{1'b0}}, rd_sel} : '0;
        end
    end

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en_q == $past(bus_wdata[NUM_SRC-1:0]))) else $error("enable write lost"); // R2
    AST_STAT_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && (evt == '0)) |=> (stat_q == $past(stat_q))) else $error("status written"); // R3
    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0) |=> ((stat_q & ~$past(stat_q)) == '0)) else $error("status set without event"); // R4
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> ((stat_q & ~$past(evt)) == '0)) else $error("status not cleared"); // R8
    AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt))) else $error("event lost"); // R9

endmodule

// File: rtl/lif_irq_unit.sv
module lif_irq_unit
    import lif_irq_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 8,
    parameter int                CNT_W   = 16,
    parameter logic [ADDR_W-1:0] EN_ADDR = 8'h01,
    parameter logic [ADDR_W-1:0] ST_ADDR = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drv_fail,
    input  logic              rx_los,
    input  logic              rx_lol,
    input  logic              fifo_near,
    input  logic              ja_en,
    input  logic              prbs_err,
    input  logic [CNT_W-1:0]  prbs_cnt,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [NUM_ALM-1:0] alm_lvl;
    logic [NUM_ALM-1:0] alm_chg;
    logic               sat_evt;
    logic               rd_clr;
    src_vec_t           evt;
    src_vec_t           en_q;
    src_vec_t           stat_q;
    src_vec_t           en_eff;

    assign alm_lvl[SRC_DRV]  = drv_fail;
    assign alm_lvl[SRC_LOS]  = rx_los;
    assign alm_lvl[SRC_LOL]  = rx_lol;
    assign alm_lvl[SRC_FIFO] = fifo_near;

    lif_alarm_edge #(
        .NUM      (NUM_ALM),
        .GATE_IDX (SRC_FIFO)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .alarm_in (alm_lvl),
        .ja_en    (ja_en),
        .chg      (alm_chg)
    );

    lif_sat_fsm #(
        .CNT_W (CNT_W)
    ) u_sat (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (prbs_cnt),
        .sat_evt (sat_evt)
    );

    always_comb begin
        evt = '0;
        evt[NUM_ALM-1:0] = alm_chg;
        evt[SRC_PRBS]    = prbs_err;
        evt[SRC_SAT]     = sat_evt;
    end

    lif_irq_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .EN_ADDR (EN_ADDR),
        .ST_ADDR (ST_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .evt       (evt),
        .en_q      (en_q),
        .stat_q    (stat_q),
        .rd_clr    (rd_clr),
        .bus_rdata (bus_rdata)
    );

    always_comb begin
        en_eff           = en_q;
        en_eff[SRC_FIFO] = en_q[SRC_FIFO] & ja_en;
    end

    assign irq = |(stat_q & en_eff);

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_clr && !(bus_sel && bus_wr)) |=> (irq || !ja_en)) else $error("irq dropped early"); // R10

endmodule

// File: tb/lif_irq_unit_tb.sv
module lif_irq_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        drv_fail = 1'b0, rx_los = 1'b0, rx_lol = 1'b0, fifo_near = 1'b0;
    logic        ja_en = 1'b0, prbs_err = 1'b0;
    logic [15:0] prbs_cnt = 16'h0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h0, bus_wdata = 8'h0;
    logic [7:0]  bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    lif_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .drv_fail(drv_fail), .rx_los(rx_los),
        .rx_lol(rx_lol), .fifo_near(fifo_near), .ja_en(ja_en),
        .prbs_err(prbs_err), .prbs_cnt(prbs_cnt), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference model
    int m_en, m_stat, m_rdata, m_lvl, m_lvl_old, m_ja, m_sat_seen;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_stat = 0; m_rdata = 0; m_lvl = 0; m_lvl_old = 0;
            m_ja = 0; m_sat_seen = 0;
        end else begin
            int ev;
            ev = m_lvl ^ m_lvl_old;
            if (m_ja == 0) ev = ev & ~8;
            if (prbs_err) ev = ev | 16;
            if (prbs_cnt == 16'hFFFF && m_sat_seen == 0) ev = ev | 32;
            m_rdata = 0;
            if (bus_sel && !bus_wr) begin
                if (bus_addr == 8'h01) m_rdata = m_en;
                else if (bus_addr == 8'h02) m_rdata = m_stat;
            end
            if (bus_sel && !bus_wr && bus_addr == 8'h02) m_stat = 0;
            m_stat = m_stat | ev;
            if (bus_sel && bus_wr && bus_addr == 8'h01) m_en = bus_wdata & 63;
            m_sat_seen = (prbs_cnt == 16'hFFFF) ? 1 : 0;
            m_lvl_old = m_lvl;
            m_lvl = {fifo_near, rx_lol, rx_los, drv_fail};
            m_ja = ja_en;
        end
    end

    function automatic bit model_irq();
        int eff;
        eff = m_en;
        if (!ja_en) eff = eff & ~8;
        return (m_stat & eff) != 0;
    endfunction

    task automatic check(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        check({cur_req, " irq"}, int'(irq), int'(model_irq()));
        check({cur_req, " rdata"}, int'(bus_rdata), m_rdata);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic bwrite(logic [7:0] a, logic [7:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bread(logic [7:0] a, output int d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        cyc();
        d = int'(bus_rdata);
        bus_sel = 0;
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        cyc();
        check("R1 irq after reset", int'(irq), 0);
        check("R1 rdata after reset", int'(bus_rdata), 0);
        bread(8'h01, d); check("R1 enable reset", d, 0);
        bread(8'h02, d); check("R1 status reset", d, 0);

        cur_req = "R2";
        bwrite(8'h01, 8'hFF);
        bread(8'h01, d); check("R2 enable upper bits zero", d, 8'h3F);
        bwrite(8'h01, 8'h15);
        bread(8'h01, d); check("R2 enable readback", d, 8'h15);
        idle(1);
        check("R8 rdata zero without read", int'(bus_rdata), 0);

        cur_req = "R3";
        bwrite(8'h02, 8'hFF);
        bread(8'h02, d); check("R3 status write ignored", d, 0);
        bread(8'h03, d); check("R3 other address reads 0", d, 0);

        cur_req = "R4";
        bwrite(8'h01, 8'h3F);
        ja_en = 1;
        idle(2);
        rx_los = 1;
        cyc(); check("R4 one edge after change", int'(irq), 0);
        cyc(); check("R4 irq after rise", int'(irq), 1);
        bread(8'h02, d); check("R4 los rise status", d, 8'h02);
        cyc(); check("R8 cleared after read", int'(irq), 0);
        rx_los = 0;
        idle(3);
        bread(8'h02, d); check("R4 los fall status", d, 8'h02);
        drv_fail = 1; rx_lol = 1;
        idle(3);
        bread(8'h02, d); check("R4 drv and lol", d, 8'h05);
        bread(8'h02, d); check("R8 second read empty", d, 0);
        drv_fail = 0; rx_lol = 0;
        idle(3);
        bread(8'h02, d); check("R4 drv and lol fall", d, 8'h05);

        cur_req = "R5";
        ja_en = 0;
        idle(2);
        fifo_near = 1;
        idle(3);
        bread(8'h02, d); check("R5 fifo ignored while ja off", d, 0);
        ja_en = 1;
        idle(3);
        bread(8'h02, d); check("R5 enabling ja makes no event", d, 0);
        bwrite(8'h01, 8'h08);
        fifo_near = 0;
        idle(3);
        check("R5 irq fifo with ja on", int'(irq), 1);
        ja_en = 0;
        cyc(); check("R5 fifo irq masked", int'(irq), 0);
        ja_en = 1;
        cyc(); check("R10 irq back with ja", int'(irq), 1);
        bread(8'h02, d); check("R5 fifo status", d, 8'h08);

        cur_req = "R6";
        bwrite(8'h01, 8'h10);
        prbs_err = 1;
        cyc(); check("R6 prbs irq", int'(irq), 1);
        prbs_err = 0;
        idle(4); check("R10 irq held", int'(irq), 1);
        bread(8'h02, d); check("R6 prbs status", d, 8'h10);

        cur_req = "R7";
        bwrite(8'h01, 8'h00);
        prbs_cnt = 16'hFFFE;
        idle(2);
        bread(8'h02, d); check("R7 not yet saturated", d, 0);
        prbs_cnt = 16'hFFFF;
        idle(1);
        bread(8'h02, d); check("R7 saturation set", d, 8'h20);
        idle(3);
        bread(8'h02, d); check("R7 not repeated while held", d, 0);
        prbs_cnt = 16'h0005;
        idle(2);
        prbs_cnt = 16'hFFFF;
        idle(2);
        bread(8'h02, d); check("R7 re-entry sets again", d, 8'h20);
        prbs_cnt = 16'h0;

        cur_req = "R9";
        bwrite(8'h01, 8'h30);
        prbs_err = 1;
        bread(8'h02, d); check("R9 read shows pre-edge value", d, 0);
        prbs_err = 0;
        cyc(); check("R9 irq kept", int'(irq), 1);
        bread(8'h02, d); check("R9 event survived read", d, 8'h10);

        cur_req = "R10";
        bwrite(8'h01, 8'h00);
        rx_los = 1;
        idle(3); check("R10 no irq when disabled", int'(irq), 0);
        bwrite(8'h01, 8'h02);
        cyc(); check("R10 irq after enable", int'(irq), 1);
        bwrite(8'h01, 8'h00);
        cyc(); check("R10 irq off after disable", int'(irq), 0);
        bread(8'h02, d); check("R10 status kept while disabled", d, 8'h02);
        rx_los = 0;
        idle(4);
        report();
    end

endmodule